// File: doc/BRIEF.md
# Asynchronous Serial Transceiver

This block sends and receives asynchronous serial characters over a pair of NRZ lines. The line rests at the mark level (high). Each character starts with one low start bit. The data bits follow, least significant first, then an optional parity bit, then one high stop bit. A single divide-by-N counter on the system clock produces a tick at sixteen times the bit rate. Both directions advance on that tick.

The transmit side has a holding register ahead of its shift register, so the next character can be queued while the current one is still on the line. The receive side assembles a character in its own shift stage. It then hands the character to a receive buffer together with noise, framing and parity indications. An overrun is reported when the buffer has not been read in time.

The receiver can be put to sleep with a one-cycle request. While asleep it keeps framing the line but reports nothing. It wakes in one of two selectable ways: after one frame time of continuous idle line, or on a character whose top data bit is set.

Top module: `sci_xcvr`

## Requirements
- R1: One sample tick occurs every 2*`cfg_div` clocks, so one bit lasts 32*`cfg_div` clocks. With `cfg_div` = 0 the generator stops, and no transmission starts.
- R2: A transmitted frame is one low start bit, then 8 data bits (`cfg_nine`=0) or 9 data bits (`cfg_nine`=1) taken LSB first from `tx_data`, then the parity bit if `cfg_par_en`=1, then one high stop bit. `txd` is high whenever no frame is being sent.
- R3: The parity bit makes the number of ones in data plus parity even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. This holds on transmit and on receive.
- R4: `tx_empty` is high while the transmit holding register is free. A `tx_load` while it is occupied is ignored. A queued character starts right after the stop bit of the current one.
- R5: While `cfg_tx_en` is low, no new frame begins and `txd` stays high. A queued character is sent once the enable returns.
- R6: A received frame with the same layout as R2 is placed in `rx_data` (bit 8 reads 0 in 8-bit mode) and sets `rx_full`. `rx_read` clears `rx_full` and all four receive error flags.
- R7: Each received bit is decided by a majority of oversamples 7, 8 and 9. If the three samples of any bit of a frame differ, `rx_noise` is set, and the data keeps the majority value.
- R8: A falling edge on `rxd` whose start bit reads high at mid-bit is discarded as a false start, and no character is produced.
- R9: A stop bit read low sets `rx_frame_err`. A received parity bit that disagrees with R3 sets `rx_par_err`.
- R10: A frame that completes while `rx_full` is high sets `rx_overrun` and is dropped. `rx_data` keeps the earlier character.
- R11: While `cfg_rx_en` is low, traffic on `rxd` produces no character and no flag.
- R12: With `cfg_wake_addr`=0, a `sleep_req` pulse sets `rx_asleep`. Frames then give no status until `rxd` has been idle high for one full frame time (16 ticks per frame bit). At that point `rx_asleep` clears and later frames are received.
- R13: With `cfg_wake_addr`=1, a sleeping receiver drops frames whose top data bit (bit 7, or bit 8 in 9-bit mode) is 0. The first frame with that bit set wakes it and is stored as a normal character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Baud divisor; 0 stops the generator |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Adds and checks a parity bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_wake_addr | input | 1 | Wake method: 1 top-bit mark, 0 idle line |
| sleep_req | input | 1 | One-cycle pulse that puts the receiver to sleep |
| tx_data | input | 9 | Character to queue |
| tx_load | input | 1 | Writes `tx_data` into the holding register |
| tx_empty | output | 1 | Holding register free |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_read | input | 1 | Consumes the received character and flags |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Received character available |
| rx_noise | output | 1 | Sample disagreement within the frame |
| rx_frame_err | output | 1 | Stop bit read low |
| rx_par_err | output | 1 | Parity mismatch |
| rx_overrun | output | 1 | A frame was lost to a full buffer |
| rx_asleep | output | 1 | Receiver dormant, waiting for wake-up |

## Verification
The bench builds the block with the default 13-bit divisor width. At run time it mostly programs a divisor of 1, which makes a bit 32 clocks long. That short bit makes a one-clock-pair glitch exactly one sixteenth of a bit, so the noise vote can be hit on a single sample. It also lets dozens of whole frames, sleep periods and idle-wake windows run in a short run. Divisors of 3 and 0 are also set at run time to check bit-length scaling and the stopped generator.

// File: rtl/sci_pkg.sv
package sci_pkg;
    // widest data word and oversampling ratio of the receiver
    localparam int WORD_MAX = 9;
    localparam int OVS      = 16;
    localparam int FRAME_W  = WORD_MAX + 3;

    typedef enum logic {
        RX_HUNT,
        RX_FRAME
    } rx_phase_e;

    typedef struct packed {
        logic [WORD_MAX-1:0] data;
        logic                noise;
        logic                ferr;
        logic                perr;
    } rx_frame_t;
endpackage

// File: rtl/sci_baud_gen.sv
module sci_baud_gen #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bg_state_t;

    bg_state_t s_d, s_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        s_d   = s_q;
        tick  = 1'b0;
        limit = {div, 1'b0} - CNT_W'(1);
        if (div == '0) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= limit) begin
            s_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sci_tx.sv
module sci_tx
    import sci_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                tx_en,
    input  logic                nine,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                load,
    input  logic [WORD_MAX-1:0] data,
    output logic                txd,
    output logic                hold_empty,
    output logic                busy
);
    typedef struct packed {
        logic [WORD_MAX-1:0] hold;
        logic                hold_full;
        logic [FRAME_W-1:0]  sh;
        logic [3:0]          left;
        logic [3:0]          sub;
        logic                busy;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic [FRAME_W-1:0] frame;
    logic [3:0] nd;
    logic [3:0] nbits;
    logic       par_bit;
    logic       last_bit;
    logic       start_ok;

    always_comb begin
        nd      = nine ? 4'd9 : 4'd8;
        nbits   = nd + 4'd2 + {3'd0, par_en};
        par_bit = par_odd;
        frame   = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < WORD_MAX; i++) begin
            if (4'(i) < nd) begin
                frame[i+1] = s_q.hold[i];
                par_bit    = par_bit ^ s_q.hold[i];
            end
        end
        if (par_en) frame[nd + 4'd1] = par_bit;

        last_bit = s_q.busy && (s_q.sub == 4'd15) && (s_q.left == 4'd1);
        start_ok = tx_en && s_q.hold_full && (!s_q.busy || last_bit);

        s_d = s_q;
        if (tick) begin
            if (start_ok) begin
                s_d.sh        = frame;
                s_d.left      = nbits;
                s_d.sub       = 4'd0;
                s_d.busy      = 1'b1;
                s_d.hold_full = 1'b0;
            end else if (s_q.busy) begin
                s_d.sub = s_q.sub + 4'd1;
                if (s_q.sub == 4'd15) begin
                    s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
                    s_d.left = s_q.left - 4'd1;
                    if (s_q.left == 4'd1) s_d.busy = 1'b0;
                end
            end
        end
        // the hand-off to the shifter frees the holding register first
        if (load && !s_d.hold_full) begin
            s_d.hold      = data;
            s_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.sh <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd        = s_q.busy ? s_q.sh[0] : 1'b1;
    assign hold_empty = !s_q.hold_full;
    assign busy       = s_q.busy;
endmodule

// File: rtl/sci_rx.sv
module sci_rx
    import sci_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_en,
    input  logic      nine,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      rxd,
    output logic      done,
    output rx_frame_t res,
    output logic      idle_hi
);
    typedef struct packed {
        logic [1:0]          sync;
        rx_phase_e           phase;
        logic [3:0]          sub;
        logic [3:0]          bi;
        logic                s7;
        logic                s8;
        logic [WORD_MAX-1:0] data;
        logic                parbit;
        logic                noise;
        logic                done;
        rx_frame_t           res;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic       line;
    logic       vote;
    logic       split;
    logic       par_calc;
    logic [3:0] nd;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], rxd};
        line     = s_q.sync[1];
        nd       = nine ? 4'd9 : 4'd8;
        vote     = (s_q.s7 & s_q.s8) | (s_q.s7 & line) | (s_q.s8 & line);
        split    = (s_q.s7 != s_q.s8) || (s_q.s8 != line);
        par_calc = s_q.parbit ^ (^s_q.data);

        if (!rx_en) begin
            s_d.phase = RX_HUNT;
        end else if (tick) begin
            if (s_q.phase == RX_HUNT) begin
                if (!line) begin
                    s_d.phase  = RX_FRAME;
                    s_d.sub    = 4'd1;
                    s_d.bi     = 4'd0;
                    s_d.data   = '0;
                    s_d.noise  = 1'b0;
                    s_d.parbit = 1'b0;
                end
            end else begin
                s_d.sub = s_q.sub + 4'd1;
                if (s_q.sub == 4'd15) s_d.bi = s_q.bi + 4'd1;
                if (s_q.sub == 4'd7) s_d.s7 = line;
                if (s_q.sub == 4'd8) s_d.s8 = line;
                if (s_q.sub == 4'd9) begin
                    if (s_q.bi == 4'd0) begin
                        if (vote) s_d.phase = RX_HUNT;
                        else      s_d.noise = s_q.noise | split;
                    end else if (s_q.bi <= nd) begin
                        s_d.data[s_q.bi - 4'd1] = vote;
                        s_d.noise = s_q.noise | split;
                    end else if (par_en && (s_q.bi == nd + 4'd1)) begin
                        s_d.parbit = vote;
                        s_d.noise  = s_q.noise | split;
                    end else begin
                        s_d.done      = 1'b1;
                        s_d.res.data  = s_q.data;
                        s_d.res.noise = s_q.noise | split;
                        s_d.res.ferr  = !vote;
                        s_d.res.perr  = par_en && (par_calc != par_odd);
                        s_d.phase     = RX_HUNT;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
            s_q.phase <= RX_HUNT;
        end else begin
            s_q <= s_d;
        end
    end

    assign done    = s_q.done;
    assign res     = s_q.res;
    assign idle_hi = rx_en && (s_q.phase == RX_HUNT) && s_q.sync[1];
endmodule

// File: rtl/sci_rx_buf.sv
module sci_rx_buf
    import sci_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                nine,
    input  logic                par_en,
    input  logic                wake_addr,
    input  logic                sleep_req,
    input  logic                rd,
    input  logic                done,
    input  rx_frame_t           res,
    input  logic                idle_hi,
    output logic [WORD_MAX-1:0] data,
    output logic                full,
    output logic                noise,
    output logic                ferr,
    output logic                perr,
    output logic                ovr,
    output logic                asleep
);
    typedef struct packed {
        logic [WORD_MAX-1:0] data;
        logic                full;
        logic                noise;
        logic                ferr;
        logic                perr;
        logic                ovr;
        logic                asleep;
        logic [7:0]          idle_cnt;
    } buf_state_t;

    buf_state_t s_d, s_q;
    logic [3:0] nb;
    logic [7:0] thr;
    logic       mark;

    always_comb begin
        s_d  = s_q;
        nb   = 4'd10 + {3'd0, nine} + {3'd0, par_en};
        thr  = {nb, 4'b0000};
        mark = nine ? res.data[8] : res.data[7];

        if (rd) begin
            s_d.full  = 1'b0;
            s_d.noise = 1'b0;
            s_d.ferr  = 1'b0;
            s_d.perr  = 1'b0;
            s_d.ovr   = 1'b0;
        end

        if (sleep_req) begin
            s_d.asleep   = 1'b1;
            s_d.idle_cnt = '0;
        end else if (s_q.asleep && !wake_addr && tick) begin
            if (!idle_hi) begin
                s_d.idle_cnt = '0;
            end else if (s_q.idle_cnt + 8'd1 >= thr) begin
                s_d.asleep   = 1'b0;
                s_d.idle_cnt = '0;
            end else begin
                s_d.idle_cnt = s_q.idle_cnt + 8'd1;
            end
        end

        if (done && !(s_q.asleep && !(wake_addr && mark))) begin
            if (s_q.asleep) s_d.asleep = 1'b0;
            if (s_d.full) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.data  = res.data;
                s_d.full  = 1'b1;
                s_d.noise = res.noise;
                s_d.ferr  = res.ferr;
                s_d.perr  = res.perr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data   = s_q.data;
    assign full   = s_q.full;
    assign noise  = s_q.noise;
    assign ferr   = s_q.ferr;
    assign perr   = s_q.perr;
    assign ovr    = s_q.ovr;
    assign asleep = s_q.asleep;
endmodule

// File: rtl/sci_xcvr.sv
module sci_xcvr
    import sci_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                cfg_nine,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_tx_en,
    input  logic                cfg_rx_en,
    input  logic                cfg_wake_addr,
    input  logic                sleep_req,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                tx_load,
    output logic                tx_empty,
    output logic                txd,
    input  logic                rxd,
    input  logic                rx_read,
    output logic [WORD_MAX-1:0] rx_data,
    output logic                rx_full,
    output logic                rx_noise,
    output logic                rx_frame_err,
    output logic                rx_par_err,
    output logic                rx_overrun,
    output logic                rx_asleep
);
    logic      baud_tick;
    logic      tx_busy;
    logic      fr_done;
    logic      fr_idle_hi;
    rx_frame_t fr_res;

    sci_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (cfg_div),
        .tick (baud_tick)
    );

    sci_tx tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .tx_en     (cfg_tx_en),
        .nine      (cfg_nine),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .load      (tx_load),
        .data      (tx_data),
        .txd       (txd),
        .hold_empty(tx_empty),
        .busy      (tx_busy)
    );

    sci_rx rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (baud_tick),
        .rx_en  (cfg_rx_en),
        .nine   (cfg_nine),
        .par_en (cfg_par_en),
        .par_odd(cfg_par_odd),
        .rxd    (rxd),
        .done   (fr_done),
        .res    (fr_res),
        .idle_hi(fr_idle_hi)
    );

    sci_rx_buf rxbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .nine     (cfg_nine),
        .par_en   (cfg_par_en),
        .wake_addr(cfg_wake_addr),
        .sleep_req(sleep_req),
        .rd       (rx_read),
        .done     (fr_done),
        .res      (fr_res),
        .idle_hi  (fr_idle_hi),
        .data     (rx_data),
        .full     (rx_full),
        .noise    (rx_noise),
        .ferr     (rx_frame_err),
        .perr     (rx_par_err),
        .ovr      (rx_overrun),
        .asleep   (rx_asleep)
    );
endmodule

// File: rtl/sci_xcvr_chk.sv
module sci_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       tx_busy,
    input logic       cfg_tx_en,
    input logic       txd,
    input logic       tx_load,
    input logic       tx_empty,
    input logic       rx_read,
    input logic       rx_full,
    input logic [8:0] rx_data,
    input logic       rx_overrun,
    input logic       rx_asleep
);
    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2
    line_mark_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R4
    hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(tx_load));

    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_tx_en && !tx_busy) |=> !tx_busy);

    // R6
    rx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rx_read));

    // R10
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $stable(rx_data));

    // R12
    dormant_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_asleep |-> !$rose(rx_full));

    // R12
    dormant_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_asleep |-> !$rose(rx_overrun));
endmodule

bind sci_xcvr sci_xcvr_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .tx_busy   (tx_busy),
    .cfg_tx_en (cfg_tx_en),
    .txd       (txd),
    .tx_load   (tx_load),
    .tx_empty  (tx_empty),
    .rx_read   (rx_read),
    .rx_full   (rx_full),
    .rx_data   (rx_data),
    .rx_overrun(rx_overrun),
    .rx_asleep (rx_asleep)
);

// File: tb/sci_xcvr_tb.sv
module sci_xcvr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_div = 13'd1;
    logic        cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic        cfg_tx_en = 1'b1, cfg_rx_en = 1'b1, cfg_wake_addr = 1'b0;
    logic        sleep_req = 1'b0;
    logic [8:0]  tx_data = '0;
    logic        tx_load = 1'b0;
    logic        tx_empty, txd;
    logic        rxd = 1'b1;
    logic        rx_read = 1'b0;
    logic [8:0]  rx_data;
    logic        rx_full, rx_noise, rx_frame_err, rx_par_err, rx_overrun, rx_asleep;

    int n_chk = 0;
    int n_fail = 0;
    int bp = 32;

    always #2 clk = ~clk;

    sci_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_nine(cfg_nine),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_tx_en(cfg_tx_en),
        .cfg_rx_en(cfg_rx_en), .cfg_wake_addr(cfg_wake_addr), .sleep_req(sleep_req),
        .tx_data(tx_data), .tx_load(tx_load), .tx_empty(tx_empty), .txd(txd),
        .rxd(rxd), .rx_read(rx_read), .rx_data(rx_data), .rx_full(rx_full),
        .rx_noise(rx_noise), .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
        .rx_overrun(rx_overrun), .rx_asleep(rx_asleep)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void build(input logic [8:0] d, input logic n9, input logic pe, input logic po,
                                  output logic [11:0] f, output int n);
        int nd;
        logic p;
        nd = n9 ? 9 : 8;
        p = po;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[i+1] = d[i];
            p = p ^ d[i];
        end
        if (pe) f[nd+1] = p;
        n = nd + 2 + (pe ? 1 : 0);
    endfunction

    task automatic load_tx(input logic [8:0] d);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic read_rx();
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic cap_tx(input int n, output logic [11:0] got);
        int w;
        w = 0;
        got = '1;
        while (txd !== 1'b0 && w < 6000) begin
            @(negedge clk);
            w++;
        end
        repeat (bp / 2) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            got[b] = txd;
            if (b < n - 1) repeat (bp) @(negedge clk);
        end
    endtask

    task automatic tx_expect(input string req, input logic [8:0] d);
        logic [11:0] f, got;
        int n;
        build(d, cfg_nine, cfg_par_en, cfg_par_odd, f, n);
        cap_tx(n, got);
        chk(req, "tx frame bits", {20'd0, got}, {20'd0, f});
    endtask

    task automatic send_rx(input logic [8:0] d, input bit bad_par, input bit bad_stop, input int glitch_bit);
        logic [11:0] f;
        int n;
        build(d, cfg_nine, cfg_par_en, cfg_par_odd, f, n);
        if (bad_par) f[n-2] = ~f[n-2];
        if (bad_stop) f[n-1] = 1'b0;
        for (int b = 0; b < n; b++) begin
            rxd = f[b];
            if (b == glitch_bit) begin
                repeat (16) @(negedge clk);
                rxd = ~f[b];
                repeat (2) @(negedge clk);
                rxd = f[b];
                repeat (bp - 18) @(negedge clk);
            end else begin
                repeat (bp) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_flags(input string req, input logic [8:0] d, input logic [4:0] fl);
        chk(req, "rx_full", {31'd0, rx_full}, 32'd1);
        chk(req, "rx_data", {23'd0, rx_data}, {23'd0, d});
        chk(req, "flags noise/ferr/perr/ovr", {28'd0, rx_noise, rx_frame_err, rx_par_err, rx_overrun},
            {28'd0, fl[3:0]});
    endtask

    task automatic t_reset();
        chk("R2", "txd at reset", {31'd0, txd}, 32'd1);
        chk("R4", "tx_empty at reset", {31'd0, tx_empty}, 32'd1);
        chk("R6", "rx status at reset", {26'd0, rx_full, rx_noise, rx_frame_err, rx_par_err, rx_overrun, rx_asleep}, 32'd0);
    endtask

    task automatic t_tx_formats();
        load_tx(9'h0A5);
        tx_expect("R2", 9'h0A5);
        cfg_nine = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        load_tx(9'h1C3);
        tx_expect("R3", 9'h1C3);
        cfg_nine = 1'b0; cfg_par_odd = 1'b1;
        load_tx(9'h070);
        tx_expect("R3", 9'h070);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_tx_buffer();
        int w;
        logic seen;
        load_tx(9'h031);
        w = 0;
        while (!tx_empty && w < 20) begin @(negedge clk); w++; end
        chk("R4", "holding freed after hand-off", {31'd0, tx_empty}, 32'd1);
        load_tx(9'h0C2);
        chk("R4", "holding occupied", {31'd0, tx_empty}, 32'd0);
        load_tx(9'h0FF);
        tx_expect("R4", 9'h031);
        tx_expect("R4", 9'h0C2);
        seen = 1'b0;
        repeat (bp * 24) begin @(negedge clk); if (txd == 1'b0) seen = 1'b1; end
        chk("R4", "load while full ignored", {31'd0, seen}, 32'd0);
    endtask

    task automatic t_tx_enable();
        logic seen;
        cfg_tx_en = 1'b0;
        load_tx(9'h03A);
        seen = 1'b0;
        repeat (800) begin @(negedge clk); if (txd == 1'b0) seen = 1'b1; end
        chk("R5", "no frame while disabled", {31'd0, seen}, 32'd0);
        chk("R5", "char stays queued", {31'd0, tx_empty}, 32'd0);
        cfg_tx_en = 1'b1;
        tx_expect("R5", 9'h03A);
    endtask

    task automatic t_baud();
        logic seen;
        cfg_div = 13'd0;
        load_tx(9'h03C);
        seen = 1'b0;
        repeat (500) begin @(negedge clk); if (txd == 1'b0) seen = 1'b1; end
        chk("R1", "div 0 no transmit", {31'd0, seen}, 32'd0);
        chk("R1", "div 0 keeps holding", {31'd0, tx_empty}, 32'd0);
        cfg_div = 13'd3; bp = 96;
        tx_expect("R1", 9'h03C);
        repeat (bp) @(negedge clk);
        cfg_div = 13'd1; bp = 32;
    endtask

    task automatic t_rx_basic();
        send_rx(9'h03C, 0, 0, -1);
        rx_flags("R6", 9'h03C, 5'b0);
        read_rx();
        chk("R6", "read clears full", {31'd0, rx_full}, 32'd0);
        cfg_nine = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        send_rx(9'h1A7, 0, 0, -1);
        rx_flags("R3", 9'h1A7, 5'b0);
        read_rx();
        send_rx(9'h0C3, 1, 0, -1);
        rx_flags("R9", 9'h0C3, 5'b0010);
        read_rx();
        chk("R6", "read clears flags", {30'd0, rx_full, rx_par_err}, 32'd0);
        cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        send_rx(9'h081, 0, 1, -1);
        repeat (bp) @(negedge clk);
        rx_flags("R9", 9'h081, 5'b0100);
        read_rx();
    endtask

    task automatic t_rx_noise_start();
        send_rx(9'h00F, 0, 0, 3);
        rx_flags("R7", 9'h00F, 5'b1000);
        read_rx();
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (bp * 12) @(negedge clk);
        chk("R8", "false start dropped", {31'd0, rx_full}, 32'd0);
        send_rx(9'h05A, 0, 0, -1);
        rx_flags("R8", 9'h05A, 5'b0);
        read_rx();
    endtask

    task automatic t_rx_overrun_en();
        send_rx(9'h011, 0, 0, -1);
        send_rx(9'h022, 0, 0, -1);
        rx_flags("R10", 9'h011, 5'b0001);
        read_rx();
        chk("R10", "read clears overrun", {30'd0, rx_full, rx_overrun}, 32'd0);
        cfg_rx_en = 1'b0;
        send_rx(9'h044, 0, 0, -1);
        chk("R11", "disabled rx ignores line", {27'd0, rx_full, rx_noise, rx_frame_err, rx_par_err, rx_overrun}, 32'd0);
        cfg_rx_en = 1'b1;
        repeat (bp) @(negedge clk);
    endtask

    task automatic t_wake();
        cfg_wake_addr = 1'b0;
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        chk("R12", "asleep after request", {31'd0, rx_asleep}, 32'd1);
        send_rx(9'h055, 0, 0, -1);
        chk("R12", "dormant frame gives no status", {30'd0, rx_full, rx_asleep}, 32'd1);
        repeat (400) @(negedge clk);
        chk("R12", "idle line wakes", {31'd0, rx_asleep}, 32'd0);
        send_rx(9'h066, 0, 0, -1);
        rx_flags("R12", 9'h066, 5'b0);
        read_rx();
        cfg_wake_addr = 1'b1;
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        send_rx(9'h012, 0, 0, -1);
        repeat (400) @(negedge clk);
        chk("R13", "no-mark frame dropped, still asleep", {30'd0, rx_full, rx_asleep}, 32'd1);
        send_rx(9'h085, 0, 0, -1);
        chk("R13", "mark frame wakes", {31'd0, rx_asleep}, 32'd0);
        rx_flags("R13", 9'h085, 5'b0);
        read_rx();
        cfg_wake_addr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_formats();
        t_tx_buffer();
        t_tx_enable();
        t_baud();
        t_rx_basic();
        t_rx_noise_start();
        t_rx_overrun_en();
        t_wake();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule